// File: doc/BRIEF.md
# Multiplexed ADC Slot Sequencer

This block shares one analog-to-digital converter among several analog inputs. It runs a repeating frame of conversion slots. Each slot has its own 4-bit select that names the input to convert. The number of slots per frame is programmable up to eleven. For every slot the sequencer drives the input select, pulses a conversion start and waits for the converter's done strobe. It then forwards the converted sample, tagged with the index of the slot that produced it.

Configuration is held in a small byte-wide register file that can be written and read back. Any of four adjacent input pairs (0/1, 2/3, 4/5, 6/7) can be switched into differential mode. A slot that names either input of such a pair then drives the pair's even input and raises a differential flag. Configuration is copied into a working set only at frame boundaries, so slot timing never changes in the middle of a frame.

Top module: `adc_slot_sequencer`

## Requirements
- R1: After reset every register reads 0, and `conv_start`, `frame_start` and `res_valid` are low.
- R2: Register map, with `cfg_rdata` valid one clock after `cfg_addr` is presented. Offset 0 holds the slot 10 select in bits [3:0] and the frame length in bits [7:4]. Offsets 1 to 5 each hold two selects: the odd slot in bits [7:4] and the even slot in bits [3:0]. Offset 5 holds slots 0/1, offset 4 slots 2/3, offset 3 slots 4/5, offset 2 slots 6/7 and offset 1 slots 8/9. A written value reads back unchanged.
- R3: With a frame length of 0 the sequencer stays idle and issues no `conv_start`.
- R4: A frame length above 11 runs frames of exactly 11 slots.
- R5: Slots run in ascending order from 0, and `slot_idx` gives the current slot. `frame_start` pulses together with the `conv_start` of slot 0 only. After the last slot, slot 0 of the next frame starts on the same edge that delivers the last result.
- R6: `conv_start` is a one-cycle pulse. `mux_sel` and `diff_flag` stay stable until `conv_done` is seen.
- R7: One clock after `conv_done`, `res_valid` pulses for one cycle. At the same time `res_data` carries `adc_data` and `res_slot` carries the slot index.
- R8: Register writes made during a frame do not change that frame's slot count or selects. They apply from the next frame boundary, and a length of 0 there stops the sequencer.
- R9: Offset 6 bits [3:0] enable differential mode for pairs 0/1, 2/3, 4/5 and 6/7 (bit k covers inputs 2k and 2k+1). For a slot whose select is 2k or 2k+1 with bit k set, `mux_sel` is 2k and `diff_flag` is 1. Otherwise `mux_sel` equals the select and `diff_flag` is 0.
- R10: Bits [7:4] of offset 6 and all of offset 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register byte offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data for `cfg_addr` |
| conv_start | output | 1 | One-cycle conversion start |
| frame_start | output | 1 | Marks the start of slot 0 |
| mux_sel | output | 4 | Analog input select for the current slot |
| diff_flag | output | 1 | Current slot uses a differential pair |
| slot_idx | output | 4 | Index of the current slot |
| conv_done | input | 1 | Conversion complete strobe |
| adc_data | input | 16 | Conversion result |
| res_valid | output | 1 | Tagged result strobe |
| res_data | output | 16 | Captured conversion result |
| res_slot | output | 4 | Slot index of the result |

## Verification
The sequencing is driven with four frame set-ups, and each one separates a different fault.
- A short frame of unrelated selects with no pairs enabled shows whether per-slot selection and ordering are correct.
- A frame mixing both inputs of two enabled pairs with a plain input shows whether the pair folding and the flag are right.
- A frame with every slot selecting its own index and the upper two pairs enabled uses an over-range length. It shows clamping, and also which pairs fold and which pass through.
- A single-slot frame that selects input 15 with all pairs enabled shows that a non-pair input is never folded.

A length-0 write made during each frame checks the boundary behaviour. It must stop the sequencer only after the frame ends, without touching the remaining slots or slot 10's select.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEQ_SEL_W     = 4;
  localparam int SEQ_MAX_SLOTS = 11;
  localparam int SEQ_NUM_PAIRS = 4;
  localparam int SEQ_LEN_W     = 4;

  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
  parameter int MAX_SLOTS = 11,
  parameter int SEL_W     = 4,
  parameter int NUM_PAIRS = 4,
  parameter int LEN_W     = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic [MAX_SLOTS*SEL_W-1:0] sel_flat,
  output logic [LEN_W-1:0]           len_raw,
  output logic [NUM_PAIRS-1:0]       diff_en
);
  // Highest selected-pair byte holds slots 0/1; offsets descend for later pairs.
  localparam int HALF     = (MAX_SLOTS - 1) / 2;
  localparam int DIFF_OFS = HALF + 1;

  function automatic logic [ADDR_W-1:0] slot_ofs(input int s);
    return ADDR_W'(HALF - s / 2);
  endfunction

  logic [7:0] rd_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_flat <= '0;
      len_raw  <= '0;
      diff_en  <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < MAX_SLOTS; s++) begin
        if (addr == slot_ofs(s))
          sel_flat[s*SEL_W +: SEL_W] <= wdata[(s%2)*SEL_W +: SEL_W];
      end
      if (addr == ADDR_W'(0))
        len_raw <= wdata[7 -: LEN_W];
      if (addr == ADDR_W'(DIFF_OFS))
        diff_en <= wdata[NUM_PAIRS-1:0];
    end
  end

  always_comb begin
    rd_c = '0;
    for (int s = 0; s < MAX_SLOTS; s++) begin
      if (addr == slot_ofs(s))
        rd_c[(s%2)*SEL_W +: SEL_W] = sel_flat[s*SEL_W +: SEL_W];
    end
    if (addr == ADDR_W'(0))
      rd_c[7 -: LEN_W] = len_raw;
    if (addr == ADDR_W'(DIFF_OFS))
      rd_c[NUM_PAIRS-1:0] = diff_en;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_c;
  end

  // R10: the unused offset never returns data
  a_r10_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(DIFF_OFS + 1)) |=> (rdata == 8'h00));
endmodule

// File: rtl/adc_seq_slot_map.sv
module adc_seq_slot_map #(
  parameter int SEL_W     = 4,
  parameter int NUM_PAIRS = 4
) (
  input  logic [SEL_W-1:0]     raw_sel,
  input  logic [NUM_PAIRS-1:0] diff_en,
  output logic [SEL_W-1:0]     eff_sel,
  output logic                 is_diff
);
  always_comb begin
    eff_sel = raw_sel;
    is_diff = 1'b0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (diff_en[p] && (raw_sel[SEL_W-1:1] == (SEL_W-1)'(p))) begin
        eff_sel = {raw_sel[SEL_W-1:1], 1'b0};
        is_diff = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int MAX_SLOTS = 11,
  parameter int SEL_W     = 4,
  parameter int NUM_PAIRS = 4,
  parameter int LEN_W     = 4,
  parameter int RES_W     = 16,
  parameter int SLOT_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [MAX_SLOTS*SEL_W-1:0] cfg_sel,
  input  logic [LEN_W-1:0]           cfg_len,
  input  logic [NUM_PAIRS-1:0]       cfg_diff,
  input  logic                       conv_done,
  input  logic [RES_W-1:0]           adc_data,
  output logic                       conv_start,
  output logic                       frame_start,
  output logic [SEL_W-1:0]           mux_sel,
  output logic                       diff_flag,
  output logic [SLOT_W-1:0]          slot_idx,
  output logic                       res_valid,
  output logic [RES_W-1:0]           res_data,
  output logic [SLOT_W-1:0]          res_slot
);
  seq_state_e                 state;
  logic [MAX_SLOTS*SEL_W-1:0] act_sel;
  logic [LEN_W-1:0]           act_len;
  logic [NUM_PAIRS-1:0]       act_diff;

  logic [LEN_W-1:0]  new_len;
  logic              last_slot;
  logic              boundary;
  logic [SLOT_W-1:0] nxt_slot;
  logic [SEL_W-1:0]  raw_sel;
  logic [NUM_PAIRS-1:0] map_diff_en;
  logic [SEL_W-1:0]  map_sel;
  logic              map_diff;

  // Frame length clamped to the slot capacity
  assign new_len   = (cfg_len > LEN_W'(MAX_SLOTS)) ? LEN_W'(MAX_SLOTS) : cfg_len;
  assign last_slot = (LEN_W'(slot_idx) == act_len - LEN_W'(1));
  assign boundary  = (state == SQ_IDLE) || last_slot;
  assign nxt_slot  = boundary ? '0 : slot_idx + SLOT_W'(1);

  always_comb begin
    if (boundary) begin
      raw_sel     = cfg_sel[SEL_W-1:0];
      map_diff_en = cfg_diff;
    end else begin
      raw_sel     = act_sel[nxt_slot*SEL_W +: SEL_W];
      map_diff_en = act_diff;
    end
  end

  adc_seq_slot_map #(.SEL_W(SEL_W), .NUM_PAIRS(NUM_PAIRS)) u_map (
    .raw_sel (raw_sel),
    .diff_en (map_diff_en),
    .eff_sel (map_sel),
    .is_diff (map_diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      act_sel     <= '0;
      act_len     <= '0;
      act_diff    <= '0;
      conv_start  <= 1'b0;
      frame_start <= 1'b0;
      mux_sel     <= '0;
      diff_flag   <= 1'b0;
      slot_idx    <= '0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_slot    <= '0;
    end else begin
      conv_start  <= 1'b0;
      frame_start <= 1'b0;
      res_valid   <= 1'b0;
      if (state == SQ_WAIT && conv_done) begin
        res_valid <= 1'b1;
        res_data  <= adc_data;
        res_slot  <= slot_idx;
      end
      if ((state == SQ_IDLE) || (state == SQ_WAIT && conv_done)) begin
        if (boundary && new_len == '0) begin
          state <= SQ_IDLE;
        end else begin
          state      <= SQ_WAIT;
          conv_start <= 1'b1;
          slot_idx   <= nxt_slot;
          mux_sel    <= map_sel;
          diff_flag  <= map_diff;
          if (boundary) begin
            frame_start <= 1'b1;
            act_sel     <= cfg_sel;
            act_len     <= new_len;
            act_diff    <= cfg_diff;
          end
        end
      end
    end
  end

  // R6: start is a single-cycle pulse
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R6: select and flag hold while the conversion is outstanding
  a_r6_sel_stable: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_WAIT && !conv_done) |=> ($stable(mux_sel) && $stable(diff_flag)));
  // R5: frame start only accompanies slot 0's start
  a_r5_frame_slot0: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (conv_start && slot_idx == '0));
  // R4: slot index never exceeds capacity
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (rst)
    slot_idx < SLOT_W'(MAX_SLOTS));
  // R7: an accepted done yields a result strobe next cycle
  a_r7_result_follows: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_WAIT && conv_done) |=> (res_valid && res_slot == $past(slot_idx)));
  // R3: idle with zero length starts nothing
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && cfg_len == '0) |=> !conv_start);
  // R8: working length is frozen inside a frame
  a_r8_len_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_WAIT && !(conv_done && last_slot)) |=> $stable(act_len));
  // R9: a differential slot always drives an even input of a pair
  a_r9_diff_even: assert property (@(posedge clk) disable iff (rst)
    diff_flag |-> (!mux_sel[0] && mux_sel < SEL_W'(2*NUM_PAIRS)));
endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer
  import adc_seq_pkg::*;
#(
  parameter int MAX_SLOTS = SEQ_MAX_SLOTS,
  parameter int SEL_W     = SEQ_SEL_W,
  parameter int NUM_PAIRS = SEQ_NUM_PAIRS,
  parameter int LEN_W     = SEQ_LEN_W,
  parameter int RES_W     = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_wr,
  input  logic [$clog2((MAX_SLOTS-1)/2+3)-1:0]   cfg_addr,
  input  logic [7:0]                             cfg_wdata,
  output logic [7:0]                             cfg_rdata,
  output logic                                   conv_start,
  output logic                                   frame_start,
  output logic [SEL_W-1:0]                       mux_sel,
  output logic                                   diff_flag,
  output logic [$clog2(MAX_SLOTS)-1:0]           slot_idx,
  input  logic                                   conv_done,
  input  logic [RES_W-1:0]                       adc_data,
  output logic                                   res_valid,
  output logic [RES_W-1:0]                       res_data,
  output logic [$clog2(MAX_SLOTS)-1:0]           res_slot
);
  localparam int ADDR_W = $clog2((MAX_SLOTS-1)/2+3);
  localparam int SLOT_W = $clog2(MAX_SLOTS);

  logic [MAX_SLOTS*SEL_W-1:0] sel_flat;
  logic [LEN_W-1:0]           len_raw;
  logic [NUM_PAIRS-1:0]       diff_en;

  adc_seq_regs #(
    .MAX_SLOTS(MAX_SLOTS), .SEL_W(SEL_W), .NUM_PAIRS(NUM_PAIRS),
    .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .sel_flat (sel_flat),
    .len_raw  (len_raw),
    .diff_en  (diff_en)
  );

  adc_seq_ctrl #(
    .MAX_SLOTS(MAX_SLOTS), .SEL_W(SEL_W), .NUM_PAIRS(NUM_PAIRS),
    .LEN_W(LEN_W), .RES_W(RES_W), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfg_sel     (sel_flat),
    .cfg_len     (len_raw),
    .cfg_diff    (diff_en),
    .conv_done   (conv_done),
    .adc_data    (adc_data),
    .conv_start  (conv_start),
    .frame_start (frame_start),
    .mux_sel     (mux_sel),
    .diff_flag   (diff_flag),
    .slot_idx    (slot_idx),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_slot    (res_slot)
  );

  // R1: no activity on the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!conv_start && !res_valid && !frame_start));
endmodule

// File: tb/adc_slot_sequencer_bench.sv
module adc_slot_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        conv_start, frame_start, diff_flag, res_valid;
  logic [3:0]  mux_sel, slot_idx, res_slot;
  logic        conv_done = 1'b0;
  logic [15:0] adc_data = '0;
  logic [15:0] res_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  adc_slot_sequencer u_adc_slot_sequencer (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .conv_start(conv_start),
    .frame_start(frame_start), .mux_sel(mux_sel), .diff_flag(diff_flag),
    .slot_idx(slot_idx), .conv_done(conv_done), .adc_data(adc_data),
    .res_valid(res_valid), .res_data(res_data), .res_slot(res_slot)
  );

  typedef struct packed {
    logic [3:0]  len;
    logic [3:0]  diff;
    logic [43:0] sels;
    logic [3:0]  n;
    logic [43:0] exps;
    logic [10:0] expd;
  } vec_t;

  // Per-slot nibbles, slot 0 in the lowest nibble
  localparam vec_t VECS [4] = '{
    '{4'd3,  4'b0000, 44'h00000000925, 4'd3,  44'h00000000925, 11'b00000000000},
    '{4'd4,  4'b0011, 44'h00000004031, 4'd4,  44'h00000004020, 11'b00000000111},
    '{4'd15, 4'b1100, 44'hA9876543210, 4'd11, 44'hA9866443210, 11'b00011110000},
    '{4'd1,  4'b1111, 44'h0000000000F, 4'd1,  44'h0000000000F, 11'b00000000000}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    cfg_addr = a;
    @(negedge clk);
    chk(req, "rdata", 32'(cfg_rdata), 32'(exp));
  endtask

  // Entered at the negedge where the slot's start pulse is visible
  task automatic do_slot(input int s, input logic [3:0] esel, input logic ed,
                         input logic stop, input logic [15:0] data);
    logic [3:0] held;
    chk("R6", "conv_start", 32'(conv_start), 32'd1);
    chk("R5", "slot_idx", 32'(slot_idx), 32'(s));
    chk("R5", "frame_start", 32'(frame_start), 32'(s == 0));
    chk("R9", "mux_sel", 32'(mux_sel), 32'(esel));
    chk("R9", "diff_flag", 32'(diff_flag), 32'(ed));
    held = mux_sel;
    @(negedge clk);
    chk("R6", "start width", 32'(conv_start), 32'd0);
    chk("R6", "sel held", 32'(mux_sel), 32'(held));
    if (stop) begin
      cfg_wr = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h00;  // R8 mid-frame stop
    end
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R7", "no early valid", 32'(res_valid), 32'd0);
    conv_done = 1'b1; adc_data = data;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R7", "res_valid", 32'(res_valid), 32'd1);
    chk("R7", "res_data", 32'(res_data), 32'(data));
    chk("R7", "res_slot", 32'(res_slot), 32'(s));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "conv_start", 32'(conv_start), 32'd0);
    chk("R1", "res_valid", 32'(res_valid), 32'd0);
    chk("R1", "frame_start", 32'(frame_start), 32'd0);
    for (int a = 0; a < 8; a++) rd("R1", 3'(a), 8'h00);

    // R2 readback and packing
    wr(3'd5, 8'hA5);
    rd("R2", 3'd5, 8'hA5);
    wr(3'd0, 8'h07);           // slot 10 select = 7, length 0
    rd("R2", 3'd0, 8'h07);
    rd("R2", 3'd1, 8'h00);
    // R10 reserved bits
    wr(3'd6, 8'hFF);
    rd("R10", 3'd6, 8'h0F);
    wr(3'd7, 8'h5A);
    rd("R10", 3'd7, 8'h00);
    // R3 zero length stays idle
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (conv_start) seen++;
    end
    chk("R3", "starts with len 0", 32'(seen), 32'd0);

    // Table walk: R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 4; v++) begin
      vec_t e;
      e = VECS[v];
      wr(3'd6, {4'h0, e.diff});
      for (int k = 0; k < 5; k++)
        wr(3'(5 - k), {e.sels[(2*k+1)*4 +: 4], e.sels[(2*k)*4 +: 4]});
      wr(3'd0, {e.len, e.sels[40 +: 4]});
      seen = 0;
      for (int t = 0; t < 10 && seen == 0; t++) begin
        if (conv_start) seen = 1;
        else @(negedge clk);
      end
      chk("R5", "frame began", 32'(seen), 32'd1);
      for (int s = 0; s < int'(e.n); s++)
        do_slot(s, e.exps[s*4 +: 4], e.expd[s], s == 0,
                16'(16'h1000 * v + 16'h11 * s + 16'h3));
      // R4/R8: frame ran its full (clamped) count, then stopped at the boundary
      seen = 0;
      repeat (12) begin
        if (conv_start) seen++;
        @(negedge clk);
      end
      chk((e.len > 4'd11) ? "R4" : "R8", "starts after frame", 32'(seen), 32'd0);
    end

    // R8: write during frame leaves current selects alone (slot 10 kept A above);
    // a new length takes effect on a fresh frame
    wr(3'd6, 8'h00);
    wr(3'd5, 8'h0C);
    wr(3'd0, 8'h10);
    seen = 0;
    for (int t = 0; t < 10 && seen == 0; t++) begin
      if (conv_start) seen = 1;
      else @(negedge clk);
    end
    chk("R8", "new frame began", 32'(seen), 32'd1);
    do_slot(0, 4'hC, 1'b0, 1'b1, 16'hBEEF);

    // R1 reset mid-operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "start after reset", 32'(conv_start), 32'd0);
    rd("R1", 3'd5, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule